// File: doc/BRIEF.md
# Floating-Point NaN Propagation Selector

This combinational block sits at the front of a two-operand single-precision arithmetic unit. It looks at two packed binary32 operands, `n` and `m`, and decides whether the operation has to return a NaN. If it does, the block produces that NaN and the invalid-operation flag. The arithmetic path uses the `nan_taken` output to decide whether to take this result or its own.

The block picks a result in one of two ways. In default-NaN mode every NaN result becomes the single canonical quiet NaN. Otherwise one input NaN is forwarded after its quiet bit is set, and the operand is chosen by a fixed priority: a signalling `n`, then a signalling `m`, then a quiet `n`, then a quiet `m`. A one-operand operation marks `m` as absent, and the block then ignores `m` completely.

Top module: `fpnan_select`

## Requirements
- R1: An operand is a NaN when its exponent field (bits 30:23) is all ones and its fraction field (bits 22:0) is nonzero. `nan_taken` is 1 exactly when `n` is a NaN, or when `m` is present and is a NaN.
- R2: When `dflt_nan_mode` is 1 and `nan_taken` is 1, `nan_res` is 0x7FC00000, whatever the payloads of the inputs.
- R3: With `dflt_nan_mode` at 0, a signalling `n` is always the operand forwarded. A NaN is signalling when fraction bit 22 is 0 and quiet when that bit is 1.
- R4: With `dflt_nan_mode` at 0, a quiet `n` is forwarded when `m` is not a signalling NaN.
- R5: With `dflt_nan_mode` at 0, `m` is forwarded in every other NaN case: when `n` is not a NaN, or when `n` is quiet and `m` is signalling.
- R6: The forwarded word keeps the sign, the exponent and fraction bits 21:0 of the chosen operand, and has bit 22 forced to 1.
- R7: `invalid_op` is 1 exactly when `n` is a signalling NaN or a present `m` is a signalling NaN. This holds in both modes.
- R8: When `m_absent` is 1, the value of `m` has no effect on `nan_taken`, `invalid_op` or `nan_res`.
- R9: When neither operand is a NaN, `nan_taken` and `invalid_op` are both 0.
- R10: An infinity (exponent all ones, fraction zero) is not treated as a NaN, in either operand position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_n | input | 32 | First operand, packed binary32 |
| op_m | input | 32 | Second operand, packed binary32 |
| m_absent | input | 1 | 1 for a one-operand operation: `op_m` is ignored |
| dflt_nan_mode | input | 1 | 1 to return the canonical quiet NaN instead of forwarding an input NaN |
| nan_res | output | 32 | NaN result. Only meaningful while `nan_taken` is 1 |
| invalid_op | output | 1 | Invalid-operation exception: a signalling NaN was seen |
| nan_taken | output | 1 | 1 when the operation must return `nan_res` |

## Verification
The block has no state, so a fault in classification or priority shows up at the ports in the same cycle as the inputs that trigger it. A fault can show up in three ways: the wrong operand's payload appears on `nan_res`, a NaN leaves with its quiet bit still clear, or `invalid_op` and `nan_taken` disagree with the input classes. Random operands are biased toward NaNs and infinities, so that every pairing of signalling, quiet and ordinary values occurs, in both modes, with and without `m`. Directed cases cover infinities, the lowest and highest payloads, and values left on an absent `m`.

// File: rtl/fpnan_pkg.sv
package fpnan_pkg;

   // Class of one operand, as far as NaN handling cares
   typedef enum logic [1:0] {
      CLS_ORD  = 2'b00,   // ordinary number, zero or infinity
      CLS_QNAN = 2'b01,
      CLS_SNAN = 2'b10,
      CLS_ABS  = 2'b11    // operand not present
   } opnd_cls_e;

   function automatic logic cls_is_nan(input opnd_cls_e c);
      return (c == CLS_QNAN) || (c == CLS_SNAN);
   endfunction

endpackage

// File: rtl/fpnan_classify.sv
module fpnan_classify
   import fpnan_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic [EXP_W+FRAC_W:0] word,
   input  logic                  present,
   output opnd_cls_e             cls
);
   localparam int QBIT = FRAC_W - 1;

   logic exp_ones;
   logic frac_nz;

   always_comb begin
      exp_ones = &word[FRAC_W +: EXP_W];
      frac_nz  = |word[FRAC_W-1:0];
      if (!present)
         cls = CLS_ABS;
      else if (exp_ones && frac_nz)
         cls = word[QBIT] ? CLS_QNAN : CLS_SNAN;
      else
         cls = CLS_ORD;
   end

   // R10
   always_comb begin
      inf_not_nan_chk: assert (!(present && exp_ones && !frac_nz) || cls == CLS_ORD);
   end
endmodule

// File: rtl/fpnan_priority.sv
module fpnan_priority
   import fpnan_pkg::*;
(
   input  opnd_cls_e cls_n,
   input  opnd_cls_e cls_m,
   output logic      any_nan,
   output logic      take_m,
   output logic      sig_seen
);
   always_comb begin
      any_nan  = cls_is_nan(cls_n) || cls_is_nan(cls_m);
      sig_seen = (cls_n == CLS_SNAN) || (cls_m == CLS_SNAN);
      // n wins when signalling, or when quiet and m is not signalling
      if (cls_n == CLS_SNAN)
         take_m = 1'b0;
      else if (cls_n == CLS_QNAN && cls_m != CLS_SNAN)
         take_m = 1'b0;
      else
         take_m = 1'b1;
   end

   // R7
   always_comb begin
      sig_implies_nan_chk: assert (!sig_seen || any_nan);
   end
   // R5
   always_comb begin
      m_pick_is_nan_chk: assert (!(any_nan && take_m) || cls_is_nan(cls_m));
   end
endmodule

// File: rtl/fpnan_format.sv
module fpnan_format #(
   parameter int EXP_W      = 8,
   parameter int FRAC_W     = 23,
   parameter bit CANON_SIGN = 1'b0
) (
   input  logic [EXP_W+FRAC_W:0] chosen,
   input  logic                  canon_mode,
   input  logic                  active,
   output logic [EXP_W+FRAC_W:0] result
);
   localparam int WORD_W = 1 + EXP_W + FRAC_W;
   localparam int QBIT   = FRAC_W - 1;

   logic [WORD_W-1:0] canon;
   logic [WORD_W-1:0] quietened;

   generate
      if (FRAC_W > 1) begin : g_wide
         assign canon = {CANON_SIGN, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
      end else begin : g_narrow
         assign canon = {CANON_SIGN, {EXP_W{1'b1}}, 1'b1};
      end
   endgenerate

   always_comb begin
      quietened       = chosen;
      quietened[QBIT] = 1'b1;
      if (!active)
         result = '0;
      else if (canon_mode)
         result = canon;
      else
         result = quietened;
   end

   // R6
   always_comb begin
      quiet_out_chk: assert (!active || (result[QBIT] && &result[FRAC_W +: EXP_W]));
   end
endmodule

// File: rtl/fpnan_select.sv
module fpnan_select
   import fpnan_pkg::*;
#(
   parameter int EXP_W      = 8,
   parameter int FRAC_W     = 23,
   parameter bit CANON_SIGN = 1'b0
) (
   input  logic [EXP_W+FRAC_W:0] op_n,
   input  logic [EXP_W+FRAC_W:0] op_m,
   input  logic                  m_absent,
   input  logic                  dflt_nan_mode,
   output logic [EXP_W+FRAC_W:0] nan_res,
   output logic                  invalid_op,
   output logic                  nan_taken
);
   localparam int WORD_W = 1 + EXP_W + FRAC_W;
   localparam int NOPS   = 2;
   localparam int QBIT   = FRAC_W - 1;

   generate
      if (EXP_W < 2) begin : g_bad_exp
         $error("fpnan_select: EXP_W must be at least 2");
      end
      if (FRAC_W < 1) begin : g_bad_frac
         $error("fpnan_select: FRAC_W must be at least 1");
      end
   endgenerate

   logic [WORD_W-1:0] ops     [NOPS];
   logic              present [NOPS];
   opnd_cls_e         cls     [NOPS];

   assign ops[0]     = op_n;
   assign ops[1]     = op_m;
   assign present[0] = 1'b1;
   assign present[1] = !m_absent;

   generate
      for (genvar i = 0; i < NOPS; i++) begin : g_cls
         fpnan_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
            .word    (ops[i]),
            .present (present[i]),
            .cls     (cls[i])
         );
      end
   endgenerate

   logic take_m;
   logic any_nan;
   logic sig_seen;

   fpnan_priority u_pri (
      .cls_n    (cls[0]),
      .cls_m    (cls[1]),
      .any_nan  (any_nan),
      .take_m   (take_m),
      .sig_seen (sig_seen)
   );

   logic [WORD_W-1:0] chosen;
   assign chosen = take_m ? op_m : op_n;

   fpnan_format #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .CANON_SIGN(CANON_SIGN)) u_fmt (
      .chosen     (chosen),
      .canon_mode (dflt_nan_mode),
      .active     (any_nan),
      .result     (nan_res)
   );

   assign nan_taken  = any_nan;
   assign invalid_op = sig_seen;

   // R2
   always_comb begin
      dflt_canon_chk: assert (!(dflt_nan_mode && nan_taken) ||
                              (nan_res[QBIT] && nan_res[QBIT-1:0] == '0 &&
                               nan_res[WORD_W-1] == CANON_SIGN));
   end
   // R9
   always_comb begin
      no_nan_quiet_chk: assert (nan_taken || !invalid_op);
   end
   // R8
   always_comb begin
      absent_m_chk: assert (!(m_absent && !(&op_n[FRAC_W +: EXP_W] && |op_n[FRAC_W-1:0]))
                            || (!nan_taken && !invalid_op));
   end
endmodule

// File: tb/sim_fpnan_select.sv
module sim_fpnan_select;
   logic        clk = 1'b0;
   logic [31:0] op_n, op_m, nan_res;
   logic        m_absent, dflt_nan_mode, invalid_op, nan_taken;
   int          n_tests = 0;
   int          n_fail  = 0;
   bit          done    = 1'b0;

   always #2.5 clk = ~clk;

   fpnan_select u0 (
      .op_n(op_n), .op_m(op_m), .m_absent(m_absent), .dflt_nan_mode(dflt_nan_mode),
      .nan_res(nan_res), .invalid_op(invalid_op), .nan_taken(nan_taken)
   );

   function automatic bit f_nan(input logic [31:0] x);
      return (x[30:23] == 8'hFF) && (x[22:0] != 0);
   endfunction
   function automatic bit f_snan(input logic [31:0] x);
      return f_nan(x) && !x[22];
   endfunction
   function automatic bit f_qnan(input logic [31:0] x);
      return f_nan(x) && x[22];
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h (n=%h m=%h abs=%0b dn=%0b)",
                  req, act, exp, op_n, op_m, m_absent, dflt_nan_mode);
      end
   endtask

   task automatic apply(input logic [31:0] n, input logic [31:0] m, input bit absent, input bit dn);
      bit          mn, ms, ex_taken, ex_inv, pick_m;
      logic [31:0] ex_res, src;
      string       tag;
      @(negedge clk);
      op_n = n; op_m = m; m_absent = absent; dflt_nan_mode = dn;
      @(posedge clk); #1;
      mn       = !absent && f_nan(m);
      ms       = !absent && f_snan(m);
      ex_taken = f_nan(n) || mn;
      ex_inv   = f_snan(n) || ms;
      pick_m   = !(f_snan(n) || (f_qnan(n) && !ms));
      src      = pick_m ? m : n;
      ex_res   = dn ? 32'h7FC00000 : (src | 32'h0040_0000);
      if (dn)                 tag = "R2";
      else if (f_snan(n))     tag = "R3";
      else if (f_qnan(n) && !ms) tag = "R4";
      else                    tag = "R5";
      chk(nan_taken == ex_taken, absent ? "R8 nan_taken" : "R1 nan_taken", {31'd0, nan_taken}, {31'd0, ex_taken});
      chk(invalid_op == ex_inv, absent ? "R8 invalid" : "R7 invalid", {31'd0, invalid_op}, {31'd0, ex_inv});
      if (ex_taken)
         chk(nan_res === ex_res, tag, nan_res, ex_res);
      if (ex_taken && !dn)
         chk(nan_res[22] && nan_res[31] == src[31] && nan_res[21:0] == src[21:0], "R6", nan_res, ex_res);
      if (!ex_taken)
         chk(!invalid_op && !nan_taken, "R9", {30'd0, invalid_op, nan_taken}, 32'd0);
   endtask

   function automatic logic [31:0] rnd_op(input int unsigned sel);
      logic [31:0] r;
      r = $urandom;
      case (sel % 5)
         0: begin r[30:23] = 8'hFF; r[22] = 1'b0; if (r[21:0] == 0) r[0] = 1'b1; end
         1: begin r[30:23] = 8'hFF; r[22] = 1'b1; end
         2: begin r[30:23] = 8'hFF; r[22:0] = '0; end
         default: ;
      endcase
      return r;
   endfunction

   initial begin
      op_n = '0; op_m = '0; m_absent = 1'b0; dflt_nan_mode = 1'b0;
      @(posedge clk); #1;
      // R9 idle state with all-zero inputs
      chk(!nan_taken && !invalid_op, "R9 idle", {30'd0, invalid_op, nan_taken}, 32'd0);
      // directed corners
      apply(32'h7F800000, 32'hFF800000, 0, 0);   // R10 infinities
      apply(32'h7F800001, 32'h7FC00000, 0, 0);   // R3 lowest sNaN payload
      apply(32'hFFC12345, 32'h7F801234, 0, 0);   // R5 quiet n vs signalling m
      apply(32'hFFC12345, 32'h7FFFFFFF, 0, 0);   // R4 both quiet
      apply(32'h3F800000, 32'hFFBFFFFF, 0, 0);   // R5 ordinary n, sNaN m
      apply(32'h7F800001, 32'h7F800002, 0, 1);   // R2 default mode, R7
      apply(32'h3F800000, 32'h7F800005, 1, 0);   // R8 absent sNaN m
      apply(32'h7FC00001, 32'h7F800005, 1, 0);   // R8 quiet n, absent sNaN m
      apply(32'h7F800000, 32'h7F800001, 0, 0);   // R10 inf n, sNaN m
      for (int i = 0; i < 3000; i++)
         apply(rnd_op($urandom), rnd_op($urandom), ($urandom % 4) == 0, ($urandom % 3) == 0);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      process::self().srandom(32'd1234);
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule